// File: doc/BRIEF.md
# Two-Level Nesting Interrupt Controller

This block sits beside a processor core and decides, from 32 level-sensitive request inputs, whether the core should take an interrupt now, which line it is, and at which of two priority levels it runs. Software programs a per-line enable mask and a per-line level mask through a small synchronous register port. It sets two global enables, one for each level, in a status word. That word also reports two active flags, which the block maintains itself.

The nesting model is fixed. A level 2 request may interrupt a running level 1 handler. A level 1 request is never taken while a level 2 handler is active, because the core keeps only one saved level 1 context. The core answers a request with an acknowledge pulse, which marks the level busy, and ends a handler with a return pulse, which retires the innermost level. A four-state machine holds the active flags: `NEST_IDLE`, `NEST_L1`, `NEST_L2`, `NEST_BOTH`. It has these transitions:

- An acknowledge of level 1 moves `NEST_IDLE` to `NEST_L1`.
- An acknowledge of level 2 moves `NEST_IDLE` to `NEST_L2`, and `NEST_L1` to `NEST_BOTH`.
- A return moves `NEST_BOTH` to `NEST_L1`, and moves `NEST_L2` or `NEST_L1` to `NEST_IDLE`.

Top module: `irq2lvl_ctrl`

## Requirements
- R1: After reset the enable mask, the level mask and all four status bits read as zero, and `take_req` is low.
- R2: The register port addresses are as follows. Address 0 is the enable mask and address 1 is the level mask; both are written whole and read back whole. Address 2 is the status word, read as {A2,A1,E2,E1} in bits 3:0 with only bits 1:0 (E2,E1) writable. Address 3 reads zero. Read data is combinational from the address.
- R3: A request line is considered only while its input is high and its enable bit is set. A line that drops before being taken leaves no trace.
- R4: A level 2 request (level-mask bit set) is raised only when E2 is 1 and A2 is 0. This holds whether or not A1 is set.
- R5: A level 1 request (level-mask bit clear) is raised only when E1 is 1 and both A1 and A2 are 0.
- R6: When both levels have an eligible line, the level 2 line is offered and `take_level` is 1.
- R7: Within the chosen level, the lowest-numbered eligible line is offered on `take_line`.
- R8: An `ack` pulse while `take_req` is high sets A2 if `take_level` is 1, otherwise A1. An `ack` while `take_req` is low changes nothing.
- R9: A `rti` pulse clears A2 if it is set, otherwise clears A1. With no flag set it changes nothing. When `rti` and `ack` arrive together, only the return is acted on.
- R10: While `take_req` is low, `take_line` and `take_level` are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data |
| take_req | output | 1 | Interrupt should be taken now |
| take_line | output | 5 | Number of the offered line |
| take_level | output | 1 | 1 = level 2, 0 = level 1 |
| ack | input | 1 | Core accepted the offered interrupt |
| rti | input | 1 | Core returned from the innermost handler |

## Verification
The assertions check several rules on every cycle. An offered line must be high and enabled, and its level must match its level-mask bit. A level 1 offer must never appear with A2 set, and a level 2 offer needs E2. An acknowledge must set the flag of its level, a return must clear A2 first, and idle outputs must stay at zero. Some behaviours can only be shown by the bench's scenarios: the lowest-number choice among several lines, level 2 winning over level 1, full read-back of the masks, and the return winning a collision with an acknowledge. The bench's reference model is compared against the outputs on every clock.

// File: rtl/irq2lvl_pkg.sv
package irq2lvl_pkg;
    typedef enum logic [1:0] {
        NEST_IDLE = 2'd0,
        NEST_L1   = 2'd1,
        NEST_L2   = 2'd2,
        NEST_BOTH = 2'd3
    } nest_state_t;

    localparam logic [1:0] ADDR_ENABLE = 2'd0;
    localparam logic [1:0] ADDR_LEVEL  = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;

    typedef struct packed {
        logic act2;
        logic act1;
        logic en2;
        logic en1;
    } status_t;
endpackage

// File: rtl/irq2lvl_regs.sv
module irq2lvl_regs
    import irq2lvl_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [1:0]   addr,
    input  logic [N-1:0] wdata,
    input  logic         act1,
    input  logic         act2,
    output logic [N-1:0] en_mask,
    output logic [N-1:0] lvl_mask,
    output logic         en1,
    output logic         en2,
    output logic [N-1:0] rdata
);
    localparam int STAT_W = $bits(status_t);

    status_t stat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_mask  <= '0;
            lvl_mask <= '0;
            en1      <= 1'b0;
            en2      <= 1'b0;
        end else if (we) begin
            unique case (addr)
                ADDR_ENABLE: en_mask  <= wdata;
                ADDR_LEVEL:  lvl_mask <= wdata;
                ADDR_STATUS: begin
                    en1 <= wdata[0];
                    en2 <= wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        stat = '{act2: act2, act1: act1, en2: en2, en1: en1};
        unique case (addr)
            ADDR_ENABLE: rdata = en_mask;
            ADDR_LEVEL:  rdata = lvl_mask;
            ADDR_STATUS: rdata = {{(N-STAT_W){1'b0}}, stat};
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq2lvl_pick.sv
module irq2lvl_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq2lvl_nest.sv
module irq2lvl_nest
    import irq2lvl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_ok,
    input  logic take_hi,
    input  logic ack,
    input  logic rti,
    output logic act1,
    output logic act2
);
    nest_state_t state_q, state_d;
    logic        accept;

    assign accept = ack && take_ok && !rti;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NEST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NEST_IDLE: begin
                if (accept) state_d = take_hi ? NEST_L2 : NEST_L1;
            end
            NEST_L1: begin
                if (rti)                    state_d = NEST_IDLE;
                else if (accept && take_hi) state_d = NEST_BOTH;
            end
            NEST_L2: begin
                if (rti) state_d = NEST_IDLE;
            end
            NEST_BOTH: begin
                if (rti) state_d = NEST_L1;
            end
            default: state_d = NEST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            NEST_IDLE: begin act1 = 1'b0; act2 = 1'b0; end
            NEST_L1:   begin act1 = 1'b1; act2 = 1'b0; end
            NEST_L2:   begin act1 = 1'b0; act2 = 1'b1; end
            NEST_BOTH: begin act1 = 1'b1; act2 = 1'b1; end
            default:   begin act1 = 1'b0; act2 = 1'b0; end
        endcase
    end
endmodule

// File: rtl/irq2lvl_ctrl.sv
module irq2lvl_ctrl #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [N-1:0]  reg_wdata,
    output logic [N-1:0]  reg_rdata,
    output logic          take_req,
    output logic [IW-1:0] take_line,
    output logic          take_level,
    input  logic          ack,
    input  logic          rti
);
    logic [N-1:0]  en_mask, lvl_mask;
    logic          en1, en2, act1, act2;
    logic [N-1:0]  pend_hi, pend_lo;
    logic          found_hi, found_lo;
    logic [IW-1:0] idx_hi, idx_lo;
    logic          elig_hi, elig_lo;

    irq2lvl_regs #(.N(N)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .act1     (act1),
        .act2     (act2),
        .en_mask  (en_mask),
        .lvl_mask (lvl_mask),
        .en1      (en1),
        .en2      (en2),
        .rdata    (reg_rdata)
    );

    assign pend_hi = irq_in & en_mask & lvl_mask;
    assign pend_lo = irq_in & en_mask & ~lvl_mask;

    irq2lvl_pick #(.N(N), .IW(IW)) u_pick_hi (
        .req   (pend_hi),
        .found (found_hi),
        .idx   (idx_hi)
    );

    irq2lvl_pick #(.N(N), .IW(IW)) u_pick_lo (
        .req   (pend_lo),
        .found (found_lo),
        .idx   (idx_lo)
    );

    assign elig_hi = found_hi && en2 && !act2;
    assign elig_lo = found_lo && en1 && !act1 && !act2;

    always_comb begin
        take_req   = elig_hi || elig_lo;
        take_level = elig_hi;
        if (elig_hi)      take_line = idx_hi;
        else if (elig_lo) take_line = idx_lo;
        else              take_line = '0;
    end

    irq2lvl_nest u_nest (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_ok (take_req),
        .take_hi (take_level),
        .ack     (ack),
        .rti     (rti),
        .act1    (act1),
        .act2    (act2)
    );
endmodule

// File: rtl/irq2lvl_chk.sv
module irq2lvl_chk #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  irq_in,
    input logic [N-1:0]  en_mask,
    input logic [N-1:0]  lvl_mask,
    input logic          en2,
    input logic          act1,
    input logic          act2,
    input logic          take_req,
    input logic [IW-1:0] take_line,
    input logic          take_level,
    input logic          ack,
    input logic          rti
);
    AST_LINE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> (irq_in[take_line] && en_mask[take_line])); // R3

    AST_HI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && take_level) |-> (en2 && !act2)); // R4

    AST_LO_NOT_UNDER_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && !take_level) |-> (!act2 && !act1)); // R5

    AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> (take_level == lvl_mask[take_line])); // R6

    AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && take_req && !rti) |=> ($past(take_level) ? act2 : act1)); // R8

    AST_RTI_INNER: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && act2) |=> (!act2 && (act1 == $past(act1)))); // R9

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take_req |-> (take_line == '0 && !take_level)); // R10
endmodule

bind irq2lvl_ctrl irq2lvl_chk #(.N(N), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .en_mask    (en_mask),
    .lvl_mask   (lvl_mask),
    .en2        (en2),
    .act1       (act1),
    .act2       (act2),
    .take_req   (take_req),
    .take_line  (take_line),
    .take_level (take_level),
    .ack        (ack),
    .rti        (rti)
);

// File: tb/sim_irq2lvl_ctrl.sv
module sim_irq2lvl_ctrl;
    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        take_req;
    logic [4:0]  take_line;
    logic        take_level;
    logic        ack = 1'b0;
    logic        rti = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] m_en = '0, m_lvl = '0;
    bit m_e1 = 0, m_e2 = 0, m_a1 = 0, m_a2 = 0;

    always #HALF clk = ~clk;

    irq2lvl_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .take_req(take_req), .take_line(take_line),
        .take_level(take_level), .ack(ack), .rti(rti)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit we, logic [1:0] addr, logic [31:0] wd,
                        logic [31:0] irq, bit a, bit r);
        bit e_req, e_lvl;
        int e_line;
        logic [31:0] e_rd;
        bit hi_any, lo_any;
        int hi_i, lo_i;
        reg_we = we; reg_addr = addr; reg_wdata = wd; irq_in = irq; ack = a; rti = r;
        hi_any = 0; lo_any = 0; hi_i = 0; lo_i = 0;
        for (int i = 31; i >= 0; i--) begin
            if (irq[i] && m_en[i] && m_lvl[i])  begin hi_any = 1; hi_i = i; end
            if (irq[i] && m_en[i] && !m_lvl[i]) begin lo_any = 1; lo_i = i; end
        end
        hi_any = hi_any && m_e2 && !m_a2;
        lo_any = lo_any && m_e1 && !m_a1 && !m_a2;
        e_req = hi_any || lo_any;
        e_lvl = hi_any;
        e_line = hi_any ? hi_i : (lo_any ? lo_i : 0);
        case (addr)
            2'd0: e_rd = m_en;
            2'd1: e_rd = m_lvl;
            2'd2: e_rd = {28'd0, m_a2, m_a1, m_e2, m_e1};
            default: e_rd = '0;
        endcase
        #2;
        check(tag, "take_req", {31'd0, take_req}, {31'd0, e_req});
        check(tag, "take_line", {27'd0, take_line}, e_line);
        check(tag, "take_level", {31'd0, take_level}, {31'd0, e_lvl});
        check(tag, "reg_rdata", reg_rdata, e_rd);
        @(posedge clk);
        if (we) begin
            case (addr)
                2'd0: m_en = wd;
                2'd1: m_lvl = wd;
                2'd2: begin m_e1 = wd[0]; m_e2 = wd[1]; end
                default: ;
            endcase
        end
        if (r) begin
            if (m_a2) m_a2 = 0; else m_a1 = 0;
        end else if (a && e_req) begin
            if (e_lvl) m_a2 = 1; else m_a1 = 1;
        end
        @(negedge clk);
        reg_we = 0; ack = 0; rti = 0;
    endtask

    task automatic rd(string tag, logic [1:0] addr, logic [31:0] irq);
        step(tag, 0, addr, '0, irq, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd("R1", 2'd0, '1);
        rd("R1", 2'd1, '1);
        rd("R1", 2'd2, '1);
        // R2 register port
        step("R2", 1, 2'd0, 32'hA5A5_0F0F, '0, 0, 0);
        rd("R2", 2'd0, '0);
        step("R2", 1, 2'd1, 32'h1234_5678, '0, 0, 0);
        rd("R2", 2'd1, '0);
        step("R2", 1, 2'd2, 32'h0000_000C, '0, 0, 0);
        rd("R2", 2'd2, '0);
        rd("R2", 2'd3, '0);
        step("R2", 1, 2'd1, 32'h0, '0, 0, 0);
        // R3 enable gating and no memory
        step("R3", 1, 2'd0, 32'h0, '0, 0, 0);
        step("R3", 1, 2'd2, 32'h1, '1, 0, 0);
        rd("R3", 2'd2, '1);
        step("R3", 1, 2'd0, 32'h0000_0020, 32'h0000_0020, 0, 0);
        rd("R3", 2'd0, 32'h0000_0020);
        rd("R3", 2'd0, 32'h0000_0000);
        rd("R10", 2'd2, 32'hFFFF_FFDF);
        // R7 lowest number within level
        step("R7", 1, 2'd0, 32'hFFFF_FFFF, 32'h0000_0110, 0, 0);
        rd("R7", 2'd2, 32'h0000_0110);
        rd("R7", 2'd2, 32'h8000_0000);
        rd("R7", 2'd2, 32'h8000_4000);
        // R8 ack sets A1, then level 1 is blocked
        step("R8", 0, 2'd2, '0, 32'h0000_0010, 1, 0);
        rd("R8", 2'd2, 32'h0000_0010);
        // R4 level 2 needs E2, may preempt A1
        step("R4", 1, 2'd1, 32'h0000_0008, 32'h0000_000A, 0, 0);
        rd("R4", 2'd2, 32'h0000_000A);
        step("R4", 1, 2'd2, 32'h3, 32'h0000_000A, 0, 0);
        rd("R4", 2'd2, 32'h0000_000A);
        step("R8", 0, 2'd2, '0, 32'h0000_000A, 1, 0);
        rd("R5", 2'd2, 32'h0000_000A);
        // R9 return order
        step("R9", 0, 2'd2, '0, 32'h0, 0, 1);
        rd("R9", 2'd2, 32'h0);
        step("R9", 0, 2'd2, '0, 32'h0, 0, 1);
        rd("R9", 2'd2, 32'h0);
        step("R9", 0, 2'd2, '0, 32'h0, 0, 1);
        rd("R9", 2'd2, 32'h0);
        // R6 level 2 wins over level 1
        rd("R6", 2'd2, 32'h0000_000A);
        rd("R6", 2'd2, 32'h0000_0009);
        // R5 level 1 blocked under A2 alone
        step("R5", 0, 2'd2, '0, 32'h0000_0008, 1, 0);
        rd("R5", 2'd2, 32'h0000_0002);
        step("R9", 0, 2'd2, '0, 32'h0, 0, 1);
        // R8 ack without request ignored
        step("R8", 0, 2'd2, '0, 32'h0, 1, 0);
        rd("R8", 2'd2, 32'h0);
        // R9 return wins over ack
        step("R9", 0, 2'd2, '0, 32'h0000_0002, 1, 0);
        step("R9", 0, 2'd2, '0, 32'h0000_0008, 1, 1);
        rd("R9", 2'd2, 32'h0);
        // R5 E1 cleared blocks level 1
        step("R5", 1, 2'd2, 32'h2, 32'h0000_0002, 0, 0);
        rd("R5", 2'd2, 32'h0000_0002);
        rd("R10", 2'd0, 32'h0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(2 * HALF * 200000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule